// File: doc/BRIEF.md
# Dual-Line Edge-Triggered Interrupt Bank

This block gathers up to 24 interrupt sources and reports them to two host masters that work independently. Every source input is synchronized, and the block watches it for the edges chosen in a single edge-configuration set. Both hosts share that set. A qualifying edge marks the source pending in the status set of each line. Each line has its own mask set. Each line also drives its own active-low interrupt output, which is asserted while any source on that line is both pending and unmasked.

A host reaches the block through a plain byte-wide register port. It can read and write status, mask, edge configuration and one control byte. A per-line control bit decides how that line's status is cleared: either reading it clears it, or writing ones to it clears it. If a source sees a second qualifying edge while it is already pending, that edge is held in a one-deep buffer. The buffered edge shows up again once the first one has been cleared.

Top module: `dual_line_irq_bank`

## Requirements
- R1: After reset, every mask bit reads 1, every status bit and edge bit reads 0, the control byte reads 0x00, and both interrupt outputs are high.
- R2: Source i takes its edge bits from edge byte i/4 at bit (i mod 4)*2. The upper bit of the pair enables rising edges. A rising edge on an enabled input sets status bit i on both lines, and the status is visible on the third clock edge after the input changes.
- R3: A source whose two edge bits are both 0 never sets a status bit.
- R4: There is a single edge-configuration set. An edge enabled in it sets the source's status on line 0 and on line 1 alike.
- R5: The 5-bit address map is as follows. Line 0 status is at 0x00 and its mask at 0x04. Line 1 status is at 0x08 and its mask at 0x0C, each taking ceil(N/8) bytes. The edge configuration sits at 0x10 and takes ceil(2N/8) bytes. The control byte is at 0x18. Unmapped addresses read 0 and ignore writes.
- R6: intN[l] is low exactly while some status bit of line l is 1 and the matching mask bit of line l is 0.
- R7: When control bit l is 0, writing 1 to a status bit of line l clears it. The same write leaves the other line unchanged.
- R8: Writing all ones to a line's mask bytes keeps that line's output high, even while status is pending.
- R9: When control bit l is 1 (bit 0 for line 0, bit 1 for line 1), reading a status byte of line l returns its bits and clears them.
- R10: When control bit l is 1, writes to line l's status bytes have no effect.
- R11: A second qualifying edge that arrives while a status bit is pending is kept. That bit reads 1 again after the first clear, and reads 0 only after a second clear.
- R12: When only the lower bit of a source's pair is set, the source reacts to falling edges and ignores rising ones.
- R13: Status and mask words are little-endian, with source i at byte i/8, bit i mod 8. Bits for indices N and above read 0.
- R14: If a clearing status read and a new qualifying edge land on the same clock edge, the new event survives and reads back as pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| srcIn | input | NUM_SRC | Raw interrupt source inputs |
| regAddr | input | 5 | Register byte address |
| regWrEn | input | 1 | Write strobe for one byte |
| regRdEn | input | 1 | Read strobe for one byte |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, valid on the clock after the read strobe |
| intN | output | 2 | Active-low interrupt outputs, bit 0 for line 0 and bit 1 for line 1 |

## Verification
A source change takes three clock edges to reach status: two synchronizer stages, then the edge compare against the previous sample. The bench therefore waits four falling edges after it drives an input before it reads status. Read data is registered, so the scoreboard queues each expected byte when the strobe is driven and compares it at the falling edge after the capturing clock. Writes and clears take effect at the capturing edge, and intN follows combinationally, so output checks are sampled at the falling edge that ends each write. In the same-edge test, the input is driven so that its edge event coincides exactly with the capturing edge of a clearing read.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;
  localparam int ADDR_W = 5;

  // decoded register access, handed from the decoder to the core
  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       selStat;
    logic       selMask;
    logic       selEdge;
    logic       selCtl;
    logic       line;
    logic [2:0] byteIdx;
  } regStrobe_t;
endpackage

// File: rtl/irq_bank_decode.sv
module irq_bank_decode
  import irq_bank_pkg::*;
#(
  parameter int STAT_BYTES = 2,
  parameter int EDGE_BYTES = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output regStrobe_t        strb
);
  localparam logic [2:0] StatLim = 3'(STAT_BYTES);
  localparam logic [2:0] EdgeLim = 3'(EDGE_BYTES);

  always_comb begin
    strb = '0;
    strb.rd = rdEn;
    strb.wr = wrEn;
    unique case (addr[4:3])
      2'b00, 2'b01: begin
        strb.line    = addr[3];
        strb.byteIdx = {1'b0, addr[1:0]};
        if ({1'b0, addr[1:0]} < StatLim) begin
          strb.selStat = ~addr[2];
          strb.selMask = addr[2];
        end
      end
      2'b10: begin
        strb.byteIdx = addr[2:0];
        strb.selEdge = addr[2:0] < EdgeLim;
      end
      default: strb.selCtl = (addr[2:0] == 3'd0);
    endcase
  end

  // R5
  one_region_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.selStat, strb.selMask, strb.selEdge, strb.selCtl}));
endmodule

// File: rtl/irq_bank_core.sv
module irq_bank_core
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  regStrobe_t         strb,
  input  logic [7:0]         wrData,
  output logic [7:0]         rdData,
  output logic [1:0]         intN
);
  localparam int STAT_BYTES = (NUM_SRC + 7) / 8;
  localparam int EDGE_BYTES = (2 * NUM_SRC + 7) / 8;
  localparam int STAT_W     = STAT_BYTES * 8;
  localparam int EDGE_W     = EDGE_BYTES * 8;

  logic [NUM_SRC-1:0]   syncA, syncB, prevQ, riseEn, fallEn, evt;
  logic [NUM_SRC-1:0]   statQ [2];
  logic [NUM_SRC-1:0]   bufQ  [2];
  logic [NUM_SRC-1:0]   maskQ [2];
  logic [NUM_SRC-1:0]   statN [2];
  logic [NUM_SRC-1:0]   bufN  [2];
  logic [NUM_SRC-1:0]   clr   [2];
  logic [STAT_W-1:0]    statPad [2];
  logic [STAT_W-1:0]    maskPad [2];
  logic [STAT_W-1:0]    maskPadN [2];
  logic [STAT_W-1:0]    clrPad [2];
  logic [2*NUM_SRC-1:0] edgeQ;
  logic [EDGE_W-1:0]    edgePad, edgePadN;
  logic [1:0]           corQ, corN;
  logic [7:0]           rdMux;

  // edge pair per source: upper bit rising, lower bit falling
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_pair
    assign riseEn[i] = edgeQ[2*i+1];
    assign fallEn[i] = edgeQ[2*i];
  end

  assign evt = (syncB & ~prevQ & riseEn) | (~syncB & prevQ & fallEn);

  always_comb begin
    rdMux    = '0;
    corN     = corQ;
    edgePad  = EDGE_W'(edgeQ);
    edgePadN = edgePad;
    for (int l = 0; l < 2; l++) begin
      statPad[l]  = STAT_W'(statQ[l]);
      maskPad[l]  = STAT_W'(maskQ[l]);
      maskPadN[l] = maskPad[l];
      clrPad[l]   = '0;
    end
    for (int b = 0; b < STAT_BYTES; b++) begin
      if (strb.byteIdx == 3'(b)) begin
        if (strb.selStat) begin
          if (strb.rd) rdMux = statPad[strb.line][b*8 +: 8];
          if (strb.rd && corQ[strb.line])
            clrPad[strb.line][b*8 +: 8] = statPad[strb.line][b*8 +: 8];
          if (strb.wr && !corQ[strb.line])
            clrPad[strb.line][b*8 +: 8] = wrData;
        end
        if (strb.selMask) begin
          if (strb.rd) rdMux = maskPad[strb.line][b*8 +: 8];
          if (strb.wr) maskPadN[strb.line][b*8 +: 8] = wrData;
        end
      end
    end
    for (int b = 0; b < EDGE_BYTES; b++) begin
      if (strb.selEdge && strb.byteIdx == 3'(b)) begin
        if (strb.rd) rdMux = edgePad[b*8 +: 8];
        if (strb.wr) edgePadN[b*8 +: 8] = wrData;
      end
    end
    if (strb.selCtl) begin
      if (strb.rd) rdMux = {6'b0, corQ};
      if (strb.wr) corN = wrData[1:0];
    end
    // one-deep buffering: a clear promotes the buffered event
    for (int l = 0; l < 2; l++) begin
      clr[l]   = clrPad[l][NUM_SRC-1:0] & statQ[l];
      statN[l] = (statQ[l] & ~clr[l]) | (bufQ[l] & clr[l]) | evt;
      bufN[l]  = (clr[l] & bufQ[l] & evt) | (~clr[l] & (bufQ[l] | (statQ[l] & evt)));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA  <= '0;
      syncB  <= '0;
      prevQ  <= '0;
      edgeQ  <= '0;
      corQ   <= '0;
      rdData <= '0;
      for (int l = 0; l < 2; l++) begin
        statQ[l] <= '0;
        bufQ[l]  <= '0;
        maskQ[l] <= '1;
      end
    end else begin
      syncA <= srcIn;
      syncB <= syncA;
      prevQ <= syncB;
      edgeQ <= edgePadN[2*NUM_SRC-1:0];
      corQ  <= corN;
      if (strb.rd) rdData <= rdMux;
      for (int l = 0; l < 2; l++) begin
        statQ[l] <= statN[l];
        bufQ[l]  <= bufN[l];
        maskQ[l] <= maskPadN[l][NUM_SRC-1:0];
      end
    end
  end

  assign intN[0] = ~|(statQ[0] & ~maskQ[0]);
  assign intN[1] = ~|(statQ[1] & ~maskQ[1]);

  // R11
  buffer_implies_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((bufQ[0] & ~statQ[0]) == '0) && ((bufQ[1] & ~statQ[1]) == '0));
  // R3
  no_spurious_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((statQ[0] & ~$past(statQ[0]) & ~$past(evt)) == '0) &&
    ((statQ[1] & ~$past(statQ[1]) & ~$past(evt)) == '0));
  // R8
  masked_line0_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ[0]) |-> intN[0]);
  // R8
  masked_line1_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (&maskQ[1]) |-> intN[1]);
endmodule

// File: rtl/dual_line_irq_bank.sv
module dual_line_irq_bank
  import irq_bank_pkg::*;
#(
  parameter int NUM_SRC = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic [4:0]         regAddr,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [7:0]         regWrData,
  output logic [7:0]         regRdData,
  output logic [1:0]         intN
);
  localparam int STAT_BYTES = (NUM_SRC + 7) / 8;
  localparam int EDGE_BYTES = (2 * NUM_SRC + 7) / 8;

  regStrobe_t strb;

  irq_bank_decode #(.STAT_BYTES(STAT_BYTES), .EDGE_BYTES(EDGE_BYTES)) u_decode (
    .clk(clk), .rstN(rstN), .addr(regAddr), .wrEn(regWrEn), .rdEn(regRdEn), .strb(strb)
  );

  irq_bank_core #(.NUM_SRC(NUM_SRC)) u_core (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .strb(strb),
    .wrData(regWrData), .rdData(regRdData), .intN(intN)
  );
endmodule

// File: tb/test_dual_line_irq_bank.sv
module test_dual_line_irq_bank;
  localparam int N = 12;
  localparam logic [4:0] S0B0 = 5'h00, S0B1 = 5'h01, M0B0 = 5'h04, M0B1 = 5'h05;
  localparam logic [4:0] S1B0 = 5'h08, S1B1 = 5'h09, M1B0 = 5'h0C;
  localparam logic [4:0] E0 = 5'h10, E1 = 5'h11, E2 = 5'h12, CTL = 5'h18;

  logic clk = 0, rstN = 0;
  logic [N-1:0] srcIn = '0;
  logic [4:0] regAddr = '0;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regWrData = '0, regRdData;
  logic [1:0] intN;
  int runCnt = 0, failCnt = 0;
  bit done = 0, rdPipe = 0;
  int expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  dual_line_irq_bank #(.NUM_SRC(N)) i_dual_line_irq_bank (
    .clk(clk), .rstN(rstN), .srcIn(srcIn), .regAddr(regAddr), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regWrData(regWrData), .regRdData(regRdData), .intN(intN)
  );

  always @(posedge clk) rdPipe <= regRdEn;

  // scoreboard monitor
  always @(negedge clk) begin
    if (rdPipe && expQ.size() > 0) begin
      int e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      runCnt++;
      if (regRdData !== 8'(e)) begin
        failCnt++;
        $display("FAIL %s: read got %02h expected %02h", t, regRdData, 8'(e));
      end
    end
  end

  task automatic readReg(input logic [4:0] a, input logic [7:0] e, input string t);
    regAddr = a; regRdEn = 1;
    expQ.push_back(int'(e)); tagQ.push_back(t);
    @(negedge clk);
    regRdEn = 0;
  endtask

  task automatic writeReg(input logic [4:0] a, input logic [7:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
  endtask

  task automatic checkInt(input logic [1:0] e, input string t);
    runCnt++;
    if (intN !== e) begin
      failCnt++;
      $display("FAIL %s: intN got %b expected %b", t, intN, e);
    end
  endtask

  task automatic setSrc(input int i, input logic v);
    srcIn[i] = v;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    checkInt(2'b11, "R1");
    readReg(S0B0, 8'h00, "R1"); readReg(S0B1, 8'h00, "R1");
    readReg(M0B0, 8'hFF, "R1"); readReg(M1B0, 8'hFF, "R1");
    readReg(E0, 8'h00, "R1");   readReg(CTL, 8'h00, "R1");
    readReg(5'h1F, 8'h00, "R5");
    // R3 no edge enabled
    setSrc(0, 1);
    readReg(S0B0, 8'h00, "R3"); readReg(S1B0, 8'h00, "R3");
    setSrc(0, 0);
    // R2 / R4 rising edge, shared config
    writeReg(E0, 8'h02);
    readReg(E0, 8'h02, "R5");
    setSrc(0, 1);
    readReg(S0B0, 8'h01, "R2"); readReg(S1B0, 8'h01, "R4");
    checkInt(2'b11, "R6");
    setSrc(0, 0);
    // R6 output per line
    writeReg(M0B0, 8'hFE); checkInt(2'b10, "R6");
    writeReg(M1B0, 8'hFE); checkInt(2'b00, "R6");
    // R7 write-one-to-clear
    writeReg(S0B0, 8'h01); checkInt(2'b01, "R7");
    readReg(S0B0, 8'h00, "R7");
    // R8 all-ones mask
    writeReg(M1B0, 8'hFF); checkInt(2'b11, "R8");
    readReg(S1B0, 8'h01, "R8");
    // R9 clear-on-read on line 1
    writeReg(CTL, 8'h02);
    readReg(S1B0, 8'h01, "R9"); readReg(S1B0, 8'h00, "R9");
    // R10 writes ignored in clear-on-read mode
    setSrc(0, 1);
    checkInt(2'b10, "R6");
    writeReg(S1B0, 8'h01);
    readReg(S1B0, 8'h01, "R10");
    writeReg(S0B0, 8'h01); checkInt(2'b11, "R7");
    setSrc(0, 0);
    // R11 second event buffered
    writeReg(E0, 8'hC2);
    setSrc(3, 1); setSrc(3, 0);
    readReg(S0B0, 8'h08, "R11"); writeReg(S0B0, 8'h08);
    readReg(S0B0, 8'h08, "R11"); writeReg(S0B0, 8'h08);
    readReg(S0B0, 8'h00, "R11");
    readReg(S1B0, 8'h08, "R11"); readReg(S1B0, 8'h08, "R11");
    readReg(S1B0, 8'h00, "R11");
    // R12 falling only
    writeReg(E1, 8'h01);
    setSrc(4, 1);
    readReg(S0B0, 8'h00, "R12");
    setSrc(4, 0);
    readReg(S0B0, 8'h10, "R12");
    writeReg(S0B0, 8'h10);
    readReg(S1B0, 8'h10, "R12"); readReg(S1B0, 8'h00, "R12");
    // R13 upper byte, padding bits
    writeReg(E2, 8'h80);
    setSrc(11, 1);
    readReg(S0B1, 8'h08, "R13"); readReg(S0B0, 8'h00, "R13");
    writeReg(M0B1, 8'hFF);
    readReg(M0B1, 8'h0F, "R13");
    checkInt(2'b11, "R6");
    writeReg(M0B1, 8'h00); checkInt(2'b10, "R6");
    readReg(S1B1, 8'h08, "R13");
    writeReg(S0B1, 8'h08); checkInt(2'b11, "R7");
    setSrc(11, 0);
    // R14 clearing read on the same edge as a new event
    setSrc(0, 1); setSrc(0, 0);
    srcIn[0] = 1;
    @(negedge clk); @(negedge clk);
    readReg(S1B0, 8'h01, "R14");
    readReg(S1B0, 8'h01, "R14");
    readReg(S1B0, 8'h00, "R14");
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      runCnt++; failCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runCnt, failCnt);
      $finish;
    end
  end
endmodule